// File: doc/BRIEF.md
# Cursor Colour Triplet Loader

This block keeps a small bank of four colour entries used by a display pipeline for the hardware cursor and the screen border. Entry 0 drives the border (overscan) colour, and entries 1 to 3 drive the three cursor colours. A host reaches the bank through a two-bit register select. One register loads the address for writes. One loads the address for reads. The third moves colour bytes. Every colour goes through the data register as three byte accesses in the order red, green, blue. A shared position counter tracks which of the three components comes next.

A write commits only on its third (blue) byte, so the outputs never show a half-written colour. Components can be 8-bit or 6-bit. In 6-bit mode, read-back is masked to six bits, and each stored component is widened to eight bits when its output colour is formed. The address register is wider than the entry select, and its low bits pick the entry, so sequential triplets step through the bank and wrap.

Top module: `cursor_color_loader`

## Requirements
- R1: After reset the address and the component position are 0, all four colour outputs are 0, and reading register 0 returns 0.
- R2: A write to register 0 (write index) loads the address with the written byte and returns the component position to red, discarding any partial triplet.
- R3: A write to register 2 (read index) loads the address with the written byte plus one and returns the position to red. A read of register 0 or register 2 returns the low 8 bits of the current address.
- R4: Writes to register 1 (data) latch red, then green. The third write stores {red, green, blue} into entry address mod 4, increments the address modulo 2^ADDR_W, and returns the position to red. No output changes before that third write.
- R5: Reads of register 1 return red, green, then blue of entry (address − 1) mod 4, and the address increments after the blue read.
- R6: With comp8_mode = 1, read-back returns full bytes and an output colour is {R, G, B} with red in bits 23:16.
- R7: With comp8_mode = 0, read-back components have bits 7:6 forced to 0. Each output component is formed at commit as {v[5:0], v[5:4]}.
- R8: cur_color1, cur_color2 and cur_color3 show the colours last committed to entries 1, 2 and 3.
- R9: A commit to entry 0 while ovs_ext_en = 1 loads ovs_color. Any other commit leaves ovs_color unchanged.
- R10: Register 3 reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access (ignored while bus_wr is high) |
| bus_reg | input | 2 | Register select: 0 write index, 1 data, 2 read index, 3 unused |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte for the selected register |
| comp8_mode | input | 1 | 1: 8-bit components, 0: 6-bit components |
| ovs_ext_en | input | 1 | Allow entry 0 commits to update the overscan colour |
| cur_color1 | output | 24 | Cursor colour from entry 1 |
| cur_color2 | output | 24 | Cursor colour from entry 2 |
| cur_color3 | output | 24 | Cursor colour from entry 3 |
| ovs_color | output | 24 | Overscan colour |

## Verification
The bench uses the defaults ADDR_W = 8 and SEL_W = 2. With an 8-bit address, writing index 0xFF and then committing one triplet is enough to show entry selection by the low two bits and wrap of the address back to 0. The two-bit entry select lets all four entries, including the border entry under both overscan settings, be written and read back through the offset-by-one read path.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int CC_COMP_W = 8;
    localparam int CC_NUM_COMP = 3;
    localparam int CC_PIX_W = CC_COMP_W * CC_NUM_COMP;

    typedef enum logic [1:0] {
        REG_WIDX = 2'd0,
        REG_DATA = 2'd1,
        REG_RIDX = 2'd2,
        REG_NONE = 2'd3
    } cc_reg_e;

    typedef enum logic [1:0] {
        POS_R = 2'd0,
        POS_G = 2'd1,
        POS_B = 2'd2
    } cc_pos_e;
endpackage

// File: rtl/cc_expand.sv
module cc_expand #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         wide_mode,
    output logic [W-1:0] pix
);
    localparam int NARROW = W - 2;

    always_comb begin
        if (wide_mode)
            pix = raw;
        else
            pix = {raw[NARROW-1:0], raw[NARROW-1:NARROW-2]};
    end
endmodule

// File: rtl/cc_rd_mux.sv
module cc_rd_mux
    import cc_pkg::*;
(
    input  logic [1:0]           reg_sel,
    input  logic [7:0]           addr_lo,
    input  logic [CC_COMP_W-1:0] comp,
    input  logic                 wide_mode,
    output logic [7:0]           rdata
);
    always_comb begin
        case (cc_reg_e'(reg_sel))
            REG_WIDX, REG_RIDX: rdata = addr_lo;
            REG_DATA:           rdata = wide_mode ? comp : {2'b00, comp[5:0]};
            default:            rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cursor_color_loader.sv
module cursor_color_loader
    import cc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_reg,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        comp8_mode,
    input  logic        ovs_ext_en,
    output logic [23:0] cur_color1,
    output logic [23:0] cur_color2,
    output logic [23:0] cur_color3,
    output logic [23:0] ovs_color
);
    localparam int N_ENT = 1 << SEL_W;

    typedef struct packed {
        logic [ADDR_W-1:0]                addr;
        cc_pos_e                          pos;
        logic [CC_COMP_W-1:0]             hold_r;
        logic [CC_COMP_W-1:0]             hold_g;
        logic [N_ENT-1:0][CC_PIX_W-1:0]   raw;
        logic [N_ENT-1:0][CC_PIX_W-1:0]   look;
        logic [CC_PIX_W-1:0]              ovs;
    } st_t;

    st_t st_d, st_q;

    logic [CC_NUM_COMP-1:0][CC_COMP_W-1:0] commit_in;
    logic [CC_NUM_COMP-1:0][CC_COMP_W-1:0] commit_pix;
    logic [SEL_W-1:0]    sel_wr;
    logic [SEL_W-1:0]    sel_rd;
    logic [CC_PIX_W-1:0] rd_entry;
    logic [CC_COMP_W-1:0] rd_comp;

    logic [ADDR_W-1:0] addr_mon;
    logic [1:0]        pos_mon;

    assign commit_in[2] = st_q.hold_r;
    assign commit_in[1] = st_q.hold_g;
    assign commit_in[0] = bus_wdata;

    generate
        for (genvar c = 0; c < CC_NUM_COMP; c++) begin : g_exp
            cc_expand #(.W(CC_COMP_W)) u_exp (
                .raw       (commit_in[c]),
                .wide_mode (comp8_mode),
                .pix       (commit_pix[c])
            );
        end
    endgenerate

    assign sel_wr   = st_q.addr[SEL_W-1:0];
    assign sel_rd   = st_q.addr[SEL_W-1:0] - SEL_W'(1);
    assign rd_entry = st_q.raw[sel_rd];

    always_comb begin
        case (st_q.pos)
            POS_R:   rd_comp = rd_entry[3*CC_COMP_W-1:2*CC_COMP_W];
            POS_G:   rd_comp = rd_entry[2*CC_COMP_W-1:CC_COMP_W];
            default: rd_comp = rd_entry[CC_COMP_W-1:0];
        endcase
    end

    cc_rd_mux u_rd (
        .reg_sel   (bus_reg),
        .addr_lo   (st_q.addr[7:0]),
        .comp      (rd_comp),
        .wide_mode (comp8_mode),
        .rdata     (bus_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (cc_reg_e'(bus_reg))
                REG_WIDX: begin
                    st_d.addr = ADDR_W'(bus_wdata);
                    st_d.pos  = POS_R;
                end
                REG_RIDX: begin
                    st_d.addr = ADDR_W'(bus_wdata) + ADDR_W'(1);
                    st_d.pos  = POS_R;
                end
                REG_DATA: begin
                    case (st_q.pos)
                        POS_R: begin
                            st_d.hold_r = bus_wdata;
                            st_d.pos    = POS_G;
                        end
                        POS_G: begin
                            st_d.hold_g = bus_wdata;
                            st_d.pos    = POS_B;
                        end
                        default: begin
                            st_d.raw[sel_wr]  = {st_q.hold_r, st_q.hold_g, bus_wdata};
                            st_d.look[sel_wr] = commit_pix;
                            if (sel_wr == '0 && ovs_ext_en)
                                st_d.ovs = commit_pix;
                            st_d.addr = st_q.addr + ADDR_W'(1);
                            st_d.pos  = POS_R;
                        end
                    endcase
                end
                default: ;
            endcase
        end else if (bus_rd && cc_reg_e'(bus_reg) == REG_DATA) begin
            case (st_q.pos)
                POS_R:   st_d.pos = POS_G;
                POS_G:   st_d.pos = POS_B;
                default: begin
                    st_d.pos  = POS_R;
                    st_d.addr = st_q.addr + ADDR_W'(1);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_color1 = st_q.look[1];
    assign cur_color2 = st_q.look[2];
    assign cur_color3 = st_q.look[3];
    assign ovs_color  = st_q.ovs;
    assign addr_mon   = st_q.addr;
    assign pos_mon    = st_q.pos;
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_reg,
    input logic [7:0]        bus_wdata,
    input logic              ovs_ext_en,
    input logic [23:0]       ovs_color,
    input logic [ADDR_W-1:0] addr_q,
    input logic [1:0]        pos_q
);
    // R4: position never leaves the three-component range
    a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q != 2'd3);

    a_r2_widx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_reg == 2'd0) |=>
            (addr_q == ADDR_W'($past(bus_wdata)) && pos_q == 2'd0));

    a_r3_ridx_preinc: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_reg == 2'd2) |=>
            (addr_q == ADDR_W'($past(bus_wdata)) + ADDR_W'(1) && pos_q == 2'd0));

    a_r4_commit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_reg == 2'd1 && pos_q == 2'd2) |=>
            (addr_q == $past(addr_q) + ADDR_W'(1) && pos_q == 2'd0));

    a_r5_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && bus_rd && bus_reg == 2'd1 && pos_q == 2'd2) |=>
            (addr_q == $past(addr_q) + ADDR_W'(1) && pos_q == 2'd0));

    a_r9_ovs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_reg == 2'd1 && pos_q == 2'd2 && addr_q[1:0] == 2'd0 && ovs_ext_en)
            |=> $stable(ovs_color));

    a_r10_unused_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_reg == 2'd3) |=> ($stable(addr_q) && $stable(pos_q)));
endmodule

bind cursor_color_loader cc_checker #(.ADDR_W(ADDR_W)) u_cc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_reg    (bus_reg),
    .bus_wdata  (bus_wdata),
    .ovs_ext_en (ovs_ext_en),
    .ovs_color  (ovs_color),
    .addr_q     (addr_mon),
    .pos_q      (pos_mon)
);

// File: tb/tb_cursor_color_loader.sv
module tb_cursor_color_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_reg = 2'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        comp8_mode = 1'b1;
    logic        ovs_ext_en = 1'b0;
    logic [23:0] cur_color1, cur_color2, cur_color3, ovs_color;

    int n_checks = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    cursor_color_loader #(.ADDR_W(8), .SEL_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .comp8_mode(comp8_mode), .ovs_ext_en(ovs_ext_en),
        .cur_color1(cur_color1), .cur_color2(cur_color2),
        .cur_color3(cur_color3), .ovs_color(ovs_color)
    );

    function automatic logic [7:0] exp6(input logic [7:0] v);
        return {v[5:0], v[5:4]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        bus_reg = r; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] r, output logic [7:0] d);
        @(negedge clk);
        bus_reg = r; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic put_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        bus_write(2'd1, r); bus_write(2'd1, g); bus_write(2'd1, b);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 cur1", cur_color1, 0); chk("R1 cur2", cur_color2, 0);
        chk("R1 cur3", cur_color3, 0); chk("R1 ovs", ovs_color, 0);
        bus_read(2'd0, d); chk("R1 addr", d, 0);
    endtask

    task automatic t_write8;
        logic [7:0] d;
        comp8_mode = 1'b1; ovs_ext_en = 1'b0;
        bus_write(2'd0, 8'd1);
        bus_write(2'd1, 8'hAA); bus_write(2'd1, 8'hBB);
        chk("R4 no early commit", cur_color1, 0);
        bus_write(2'd1, 8'hCC);
        chk("R6 R8 cur1", cur_color1, 24'hAABBCC);
        bus_read(2'd0, d); chk("R4 addr inc", d, 8'd2);
        put_rgb(8'h11, 8'h22, 8'h33);
        put_rgb(8'h44, 8'h55, 8'h66);
        chk("R8 cur2", cur_color2, 24'h112233);
        chk("R8 cur3", cur_color3, 24'h445566);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        bus_write(2'd2, 8'd1);
        bus_read(2'd2, d); chk("R3 preinc", d, 8'd2);
        bus_read(2'd1, d); chk("R5 red", d, 8'hAA);
        bus_read(2'd1, d); chk("R5 green", d, 8'hBB);
        bus_read(2'd1, d); chk("R5 blue", d, 8'hCC);
        bus_read(2'd0, d); chk("R5 addr after blue", d, 8'd3);
        bus_read(2'd1, d); chk("R5 next red", d, 8'h11);
        bus_read(2'd1, d); chk("R5 next green", d, 8'h22);
        bus_read(2'd1, d); chk("R6 next blue", d, 8'h33);
    endtask

    task automatic t_pos_reset;
        bus_write(2'd0, 8'd3);
        bus_write(2'd1, 8'h01); bus_write(2'd1, 8'h02);
        bus_write(2'd0, 8'd3);
        put_rgb(8'h07, 8'h08, 8'h09);
        chk("R2 partial dropped", cur_color3, 24'h070809);
    endtask

    task automatic t_six;
        logic [7:0] d;
        comp8_mode = 1'b0;
        bus_write(2'd0, 8'd2);
        put_rgb(8'hFF, 8'h3A, 8'h15);
        chk("R7 expand", cur_color2, {exp6(8'hFF), exp6(8'h3A), exp6(8'h15)});
        bus_write(2'd2, 8'd2);
        bus_read(2'd1, d); chk("R7 mask red", d, 8'h3F);
        bus_read(2'd1, d); chk("R7 mask green", d, 8'h3A);
        bus_read(2'd1, d); chk("R7 mask blue", d, 8'h15);
        comp8_mode = 1'b1;
    endtask

    task automatic t_ovs;
        ovs_ext_en = 1'b0;
        bus_write(2'd0, 8'd0);
        put_rgb(8'h12, 8'h34, 8'h56);
        chk("R9 disabled hold", ovs_color, 0);
        ovs_ext_en = 1'b1;
        bus_write(2'd0, 8'd0);
        put_rgb(8'h9A, 8'hBC, 8'hDE);
        chk("R9 load", ovs_color, 24'h9ABCDE);
        put_rgb(8'h01, 8'h01, 8'h01);
        chk("R9 other entry hold", ovs_color, 24'h9ABCDE);
        chk("R8 cur1 after ovs", cur_color1, 24'h010101);
        ovs_ext_en = 1'b0;
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        bus_write(2'd0, 8'hFF);
        put_rgb(8'hA1, 8'hA2, 8'hA3);
        chk("R4 entry by low bits", cur_color3, 24'hA1A2A3);
        bus_read(2'd0, d); chk("R4 addr wrap", d, 8'h00);
    endtask

    task automatic t_code3;
        logic [7:0] d;
        bus_write(2'd0, 8'd5);
        bus_write(2'd3, 8'h55);
        bus_read(2'd3, d); chk("R10 reads zero", d, 8'h00);
        bus_read(2'd0, d); chk("R10 addr kept", d, 8'd5);
        chk("R10 cur1 kept", cur_color1, 24'h010101);
        bus_write(2'd1, 8'h77);
        bus_write(2'd3, 8'h00);
        bus_write(2'd1, 8'h78); bus_write(2'd1, 8'h79);
        chk("R10 pos kept", cur_color1, 24'h777879);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write8();
        t_readback();
        t_pos_reset();
        t_six();
        t_ovs();
        t_wrap();
        t_code3();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule